// File: doc/BRIEF.md
# Counted-Enable Interrupt Pending Aggregator

This block tracks a fixed set of interrupt sources and reduces them to one CPU interrupt request. A source does not have a single mask bit. It has a small enable counter and a fixed target value: the number of mask registers and group masks that must all enable it. The decode logic outside the block sends a one-cycle increment or decrement pulse for each source whenever one of those contributors changes. A source is pending only when it is asserted and its counter has reached the target.

The block keeps a running count of pending sources and drives the interrupt request from that count. The CPU side can query the block with its current interrupt mask level. The answer, one cycle later, is the vector code of the lowest-numbered pending source.

The upper part of the source array forms a chain of fifteen level sources. A 4-bit encoded level drives this chain, so a priority-encoded external request can be brought in without fifteen separate wires. Register decode, arbitration by priority and the CPU itself are outside this block.

Top module: `intc_cnt_agg`

## Requirements
- R1: While reset is held and after it is released, `irq_o`, `pend_cnt_o`, `vec_valid_o` and `vec_err_o` read 0, and every enable counter and asserted flag is clear.
- R2: A source is pending exactly when it is asserted and its enable counter equals its configured target. A source whose target is 0 is pending as soon as it is asserted.
- R3: An enable counter saturates. An increment pulse at the target and a decrement pulse at 0 leave it unchanged.
- R4: A general source's asserted flag follows its level input one clock later. Holding the same level causes no change.
- R5: `pend_cnt_o` equals the number of pending sources. It is updated in the same clock edge as the pending state.
- R6: `irq_o` is high exactly when the pending count is nonzero, with the same timing as `pend_cnt_o`.
- R7: A query is answered one cycle later from the pending state held at the query edge:
  - When `imask_i` is 15, `vec_valid_o` stays 0.
  - Otherwise, if any source is pending, `vec_valid_o` is 1 and `vec_o` is `VEC_BASE + k*VEC_STEP`, where k is the lowest index of a pending source.
  - `vec_valid_o` is 0 in any cycle that follows no query.
- R8: On a level update strobe, chain position p = `lvl_i` XOR 15 (source index `N_GEN+p`) is asserted and every other chain source is deasserted. A level of 0 selects p = 15, which does not exist, so it clears the whole chain. Chain sources hold their state between strobes.
- R9: On a level update strobe, the selected chain source's counter is raised by one if it would otherwise be 0 and its target is nonzero.
- R10: `vec_err_o` rises only when a query under a mask level other than 15 finds the pending count nonzero but no pending source. A query that finds nothing pending returns `vec_valid_o` 0.
- R11: An increment pulse and a decrement pulse that reach the same source in the same cycle cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_level_i | input | N_GEN | Level requests of the general sources |
| en_up_i | input | N_SRC | Enable increment pulse per source |
| en_dn_i | input | N_SRC | Enable decrement pulse per source |
| lvl_we_i | input | 1 | Strobe that applies `lvl_i` to the level chain |
| lvl_i | input | 4 | Encoded level, 0 none, 15 highest |
| query_i | input | 1 | Vector query request |
| imask_i | input | 4 | CPU interrupt mask level for the query |
| irq_o | output | 1 | Interrupt request to the CPU |
| pend_cnt_o | output | CW | Number of pending sources |
| vec_valid_o | output | 1 | Query answer carries a vector |
| vec_o | output | VEC_W | Vector code of the lowest pending source |
| vec_err_o | output | 1 | Query found the count and the pending set inconsistent |

## Verification
The hardest state to reach is a source whose counter sits at an extreme while pulses keep arriving. Examples are a counter already at its target receiving another increment, or a counter at 0 receiving another decrement. The same difficulty applies when a level strobe selects a chain source whose counter has just been pulled back to 0. Directed sequences drive each of these in turn: repeated pulses to one source, pulses that collide in the same cycle, and a decrement followed by a re-strobe of the same level. A long seeded random run then mixes level toggles, sparse pulses and level strobes. It is checked every cycle against a counter model in the bench, which observes the counters through the pending count and the query answer.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned LVL_N = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] LVL_FLIP = '1;

  function automatic logic [15:0] vec_code(input int unsigned idx,
                                           input logic [15:0] base,
                                           input logic [15:0] step);
    return base + 16'(idx) * step;
  endfunction
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell #(
  parameter int unsigned       CNT_W = 2,
  parameter logic [CNT_W-1:0]  MAX   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             force_i,
  output logic             asrt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o,
  output logic             pend_d_o
);
  logic [CNT_W-1:0] cnt_q, cnt_adj, cnt_d;
  logic             asrt_q, asrt_d, pend_q;

  always_comb begin
    cnt_adj = cnt_q;
    if (up_i && !dn_i && cnt_q != MAX)      cnt_adj = cnt_q + 1'b1;
    else if (dn_i && !up_i && cnt_q != '0)  cnt_adj = cnt_q - 1'b1;
    cnt_d = cnt_adj;
    // level strobe turns the selected chain entry on when nothing enabled it
    if (force_i && cnt_adj == '0 && MAX != '0) cnt_d = cnt_adj + 1'b1;
  end

  always_comb begin
    asrt_d = asrt_q;
    if (set_i)      asrt_d = 1'b1;
    else if (clr_i) asrt_d = 1'b0;
  end

  assign pend_d_o = asrt_d && (cnt_d == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      asrt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      asrt_q <= asrt_d;
      pend_q <= pend_d_o;
    end
  end

  assign asrt_o = asrt_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/intc_pend_cnt.sv
module intc_pend_cnt #(
  parameter int unsigned N  = 23,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_q_i,
  input  logic [N-1:0]  pend_d_i,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o
);
  logic [N-1:0]  rise, fall;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q;

  assign rise  = pend_d_i & ~pend_q_i;
  assign fall  = pend_q_i & ~pend_d_i;
  assign cnt_d = cnt_q + CW'($countones(rise)) - CW'($countones(fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= (cnt_d != '0);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/intc_vec_sel.sv
module intc_vec_sel #(
  parameter int unsigned N        = 23,
  parameter int unsigned CW       = $clog2(N + 1),
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0200,
  parameter logic [15:0] VEC_STEP = 16'h0020
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             query_i,
  input  logic [3:0]       imask_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             err_o
);
  logic             hit, search;
  int unsigned      idx;
  logic [VEC_W-1:0] vec_d;
  logic             valid_q, err_q;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    hit = 1'b0;
    idx = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        hit = 1'b1;
        idx = i;
      end
    end
  end

  assign search = query_i && (imask_i != 4'hF);
  assign vec_d  = VEC_W'(intc_pkg::vec_code(idx, VEC_BASE, VEC_STEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= search && hit;
      err_q   <= search && !hit && (cnt_i != '0);
      if (search && hit) vec_q <= vec_d;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;
  assign err_o   = err_q;
endmodule

// File: rtl/intc_cnt_agg.sv
module intc_cnt_agg #(
  parameter int unsigned               N_GEN     = 8,
  parameter int unsigned               CNT_W     = 2,
  parameter logic [N_GEN*CNT_W-1:0]    GEN_MAX   = 16'hD899,
  parameter logic [CNT_W-1:0]          CHAIN_MAX = 2'd1,
  parameter int unsigned               VEC_W     = 16,
  parameter logic [15:0]               VEC_BASE  = 16'h0200,
  parameter logic [15:0]               VEC_STEP  = 16'h0020,
  localparam int unsigned              N_SRC     = N_GEN + intc_pkg::LVL_N,
  localparam int unsigned              CW        = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_GEN-1:0] src_level_i,
  input  logic [N_SRC-1:0] en_up_i,
  input  logic [N_SRC-1:0] en_dn_i,
  input  logic             lvl_we_i,
  input  logic [3:0]       lvl_i,
  input  logic             query_i,
  input  logic [3:0]       imask_i,
  output logic             irq_o,
  output logic [CW-1:0]    pend_cnt_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_err_o
);
  logic [N_SRC-1:0]       set, clr, frc, asrt_q, pend_q, pend_d;
  logic [N_SRC*CNT_W-1:0] cnt_flat;
  logic [3:0]             lvl_pos;

  assign lvl_pos = lvl_i ^ intc_pkg::LVL_FLIP;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (g < N_GEN) begin : g_gen
      assign set[g] = src_level_i[g] && !asrt_q[g];
      assign clr[g] = !src_level_i[g] && asrt_q[g];
      assign frc[g] = 1'b0;
      intc_src_cell #(.CNT_W(CNT_W), .MAX(GEN_MAX[g*CNT_W +: CNT_W])) u_cell (
        .clk_i, .rst_ni,
        .set_i(set[g]), .clr_i(clr[g]),
        .up_i(en_up_i[g]), .dn_i(en_dn_i[g]), .force_i(frc[g]),
        .asrt_o(asrt_q[g]), .cnt_o(cnt_flat[g*CNT_W +: CNT_W]),
        .pend_o(pend_q[g]), .pend_d_o(pend_d[g]));
    end else begin : g_lvl
      logic hit;
      assign hit    = lvl_we_i && (lvl_pos == 4'(g - N_GEN));
      assign set[g] = hit;
      assign clr[g] = lvl_we_i && !hit;
      assign frc[g] = hit;
      intc_src_cell #(.CNT_W(CNT_W), .MAX(CHAIN_MAX)) u_cell (
        .clk_i, .rst_ni,
        .set_i(set[g]), .clr_i(clr[g]),
        .up_i(en_up_i[g]), .dn_i(en_dn_i[g]), .force_i(frc[g]),
        .asrt_o(asrt_q[g]), .cnt_o(cnt_flat[g*CNT_W +: CNT_W]),
        .pend_o(pend_q[g]), .pend_d_o(pend_d[g]));
    end
  end

  intc_pend_cnt #(.N(N_SRC), .CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .pend_q_i(pend_q), .pend_d_i(pend_d),
    .cnt_o(pend_cnt_o), .irq_o(irq_o));

  intc_vec_sel #(.N(N_SRC), .CW(CW), .VEC_W(VEC_W),
                 .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_vec (
    .clk_i, .rst_ni,
    .pend_i(pend_q), .cnt_i(pend_cnt_o),
    .query_i, .imask_i,
    .valid_o(vec_valid_o), .vec_o(vec_o), .err_o(vec_err_o));
endmodule

// File: rtl/intc_cnt_agg_chk.sv
module intc_cnt_agg_chk #(
  parameter int unsigned            N_GEN     = 8,
  parameter int unsigned            CNT_W     = 2,
  parameter logic [N_GEN*CNT_W-1:0] GEN_MAX   = 16'hD899,
  parameter logic [CNT_W-1:0]       CHAIN_MAX = 2'd1,
  localparam int unsigned           N_SRC     = N_GEN + intc_pkg::LVL_N,
  localparam int unsigned           CW        = $clog2(N_SRC + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_GEN-1:0]       src_level_i,
  input logic [N_SRC-1:0]       en_up_i,
  input logic [N_SRC-1:0]       en_dn_i,
  input logic                   lvl_we_i,
  input logic                   query_i,
  input logic [3:0]             imask_i,
  input logic                   irq_o,
  input logic [CW-1:0]          pend_cnt_o,
  input logic                   vec_valid_o,
  input logic                   vec_err_o,
  input logic [N_SRC-1:0]       asrt_i,
  input logic [N_SRC-1:0]       pend_i,
  input logic [N_SRC*CNT_W-1:0] cnt_i
);
  p_cnt_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pend_cnt_o) == $countones(pend_i));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend_cnt_o != '0));

  p_mask_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_i && imask_i == 4'hF) |=> !vec_valid_o);

  p_no_query_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !query_i |=> !vec_valid_o);

  p_chain_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_we_i |=> $onehot0(asrt_i[N_SRC-1:N_GEN]));

  p_no_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_err_o);

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    localparam logic [CNT_W-1:0] MX = (g < N_GEN) ? GEN_MAX[g*CNT_W +: CNT_W] : CHAIN_MAX;

    p_cnt_le_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[g*CNT_W +: CNT_W] <= MX);

    p_sat_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[g*CNT_W +: CNT_W] == '0 && en_dn_i[g] && !en_up_i[g] && !lvl_we_i)
      |=> cnt_i[g*CNT_W +: CNT_W] == '0);

    p_cancel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_up_i[g] && en_dn_i[g] && !lvl_we_i) |=> $stable(cnt_i[g*CNT_W +: CNT_W]));

    if (g < N_GEN) begin : g_gen
      p_level_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> asrt_i[g] == $past(src_level_i[g]));
    end
  end
endmodule

bind intc_cnt_agg intc_cnt_agg_chk #(
  .N_GEN(N_GEN), .CNT_W(CNT_W), .GEN_MAX(GEN_MAX), .CHAIN_MAX(CHAIN_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_level_i(src_level_i),
  .en_up_i(en_up_i), .en_dn_i(en_dn_i), .lvl_we_i(lvl_we_i),
  .query_i(query_i), .imask_i(imask_i), .irq_o(irq_o),
  .pend_cnt_o(pend_cnt_o), .vec_valid_o(vec_valid_o), .vec_err_o(vec_err_o),
  .asrt_i(asrt_q), .pend_i(pend_q), .cnt_i(cnt_flat));

// File: tb/intc_cnt_agg_tb.sv
`timescale 1ns/1ps
module intc_cnt_agg_tb;
  localparam int N_GEN = 8;
  localparam int N_SRC = N_GEN + 15;
  localparam int CW    = $clog2(N_SRC + 1);
  localparam int BASE  = 'h200;
  localparam int STEP  = 'h20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_GEN-1:0] src_level = '0;
  logic [N_SRC-1:0] en_up = '0, en_dn = '0;
  logic             lvl_we = 1'b0;
  logic [3:0]       lvl = '0;
  logic             query = 1'b0;
  logic [3:0]       imask = '0;
  logic             irq, vec_valid, vec_err;
  logic [CW-1:0]    pend_cnt;
  logic [15:0]      vec;

  int  n_chk = 0, n_fail = 0;
  int  m_cnt [N_SRC];
  bit  m_asrt[N_SRC];
  bit  done = 1'b0;

  always #2 clk = ~clk;

  intc_cnt_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_level_i(src_level),
    .en_up_i(en_up), .en_dn_i(en_dn), .lvl_we_i(lvl_we), .lvl_i(lvl),
    .query_i(query), .imask_i(imask), .irq_o(irq), .pend_cnt_o(pend_cnt),
    .vec_valid_o(vec_valid), .vec_o(vec), .vec_err_o(vec_err));

  function automatic int mx(input int i);
    int tbl[N_GEN] = '{1, 2, 1, 2, 0, 2, 1, 3};
    return (i < N_GEN) ? tbl[i] : 1;
  endfunction

  function automatic bit m_pend(input int i);
    return m_asrt[i] && (m_cnt[i] == mx(i));
  endfunction

  function automatic int m_total();
    int t = 0;
    for (int i = 0; i < N_SRC; i++) t += int'(m_pend(i));
    return t;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic step(input logic [N_GEN-1:0] lv, input logic [N_SRC-1:0] up,
                      input logic [N_SRC-1:0] dn, input logic lwe,
                      input logic [3:0] lv4, input logic q, input logic [3:0] im);
    int  n_cnt[N_SRC];
    bit  n_asrt[N_SRC];
    bit  e_valid = 1'b0;
    int  e_vec = 0;
    if (q && im != 4'hF)
      for (int i = 0; i < N_SRC; i++)
        if (!e_valid && m_pend(i)) begin e_valid = 1'b1; e_vec = BASE + i * STEP; end
    for (int i = 0; i < N_SRC; i++) begin
      int c = m_cnt[i];
      bit a;
      if (up[i] && !dn[i] && c != mx(i))      c++;
      else if (dn[i] && !up[i] && c != 0)     c--;
      if (i < N_GEN) a = lv[i];
      else if (lwe) begin
        a = ((lv4 ^ 4'hF) == 4'(i - N_GEN));
        if (a && c == 0 && mx(i) != 0) c++;
      end else a = m_asrt[i];
      n_cnt[i] = c;
      n_asrt[i] = a;
    end
    src_level = lv; en_up = up; en_dn = dn; lvl_we = lwe; lvl = lv4;
    query = q; imask = im;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N_SRC; i++) begin m_cnt[i] = n_cnt[i]; m_asrt[i] = n_asrt[i]; end
    chk("R5 pend_cnt", int'(pend_cnt), m_total());
    chk("R6 irq", int'(irq), int'(m_total() != 0));
    chk("R7 vec_valid", int'(vec_valid), int'(e_valid));
    if (e_valid) chk("R7 vec", int'(vec), e_vec);
    chk("R10 vec_err", int'(vec_err), 0);
  endtask

  function automatic logic [N_SRC-1:0] bit_at(input int i);
    return N_SRC'(1) << i;
  endfunction

  initial begin
    logic [N_GEN-1:0] lv;
    void'($urandom(32'd5150));
    for (int i = 0; i < N_SRC; i++) begin m_cnt[i] = 0; m_asrt[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 pend_cnt in reset", int'(pend_cnt), 0);
    chk("R1 vec_valid in reset", int'(vec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pend_cnt after reset", int'(pend_cnt), 0);

    lv = 8'b0000_0010;
    step(lv, '0, '0, 0, 0, 0, 0);
    chk("R2 asserted without enables", int'(pend_cnt), 0);
    step(lv, bit_at(1), '0, 0, 0, 0, 0);
    chk("R2 one of two enables", int'(pend_cnt), 0);
    step(lv, bit_at(1), '0, 0, 0, 0, 0);
    chk("R2 both enables", int'(pend_cnt), 1);
    step(lv, '0, '0, 0, 0, 0, 0);
    chk("R4 held level", int'(pend_cnt), 1);
    step(lv, bit_at(1), '0, 0, 0, 0, 0);
    step(lv, '0, bit_at(1), 0, 0, 0, 0);
    chk("R3 saturate at max", int'(pend_cnt), 0);
    step(lv, '0, bit_at(1), 0, 0, 0, 0);
    step(lv, '0, bit_at(1), 0, 0, 0, 0);
    step(lv, bit_at(1), '0, 0, 0, 0, 0);
    chk("R3 saturate at zero", int'(pend_cnt), 0);
    step(lv, bit_at(1), '0, 0, 0, 0, 0);
    chk("R3 recount", int'(pend_cnt), 1);

    lv = 8'b0001_1010;
    step(lv, '0, '0, 0, 0, 1, 4'h0);
    chk("R2 zero target", int'(pend_cnt), 2);
    step(lv, '0, '0, 0, 0, 1, 4'h3);
    chk("R7 lowest index", int'(vec), BASE + 1 * STEP);
    step(lv, '0, '0, 0, 0, 1, 4'hF);
    chk("R7 mask 15", int'(vec_valid), 0);

    step(lv, bit_at(3), bit_at(3), 0, 0, 0, 0);
    step(lv, bit_at(3), '0, 0, 0, 0, 0);
    step(lv, bit_at(3), bit_at(3), 0, 0, 0, 0);
    chk("R11 cancel", int'(pend_cnt), 2);
    step(lv, bit_at(3), '0, 0, 0, 0, 0);
    chk("R11 after cancel", int'(pend_cnt), 3);

    lv = 8'b0001_1000;
    step(lv, '0, '0, 0, 0, 0, 0);
    chk("R4 level drop", int'(pend_cnt), 2);

    step(lv, '0, '0, 1, 4'd15, 0, 0);
    chk("R8 R9 level 15", int'(pend_cnt), 3);
    step(lv, '0, '0, 1, 4'd1, 1, 4'h0);
    chk("R8 level 1 moves", int'(pend_cnt), 3);
    step(lv, '0, '0, 1, 4'd0, 0, 0);
    chk("R8 level 0 clears", int'(pend_cnt), 2);
    step(lv, '0, '0, 1, 4'd15, 0, 0);
    step(lv, '0, bit_at(N_GEN), 0, 0, 0, 0);
    chk("R9 drop enable", int'(pend_cnt), 2);
    step(lv, '0, '0, 1, 4'd15, 0, 0);
    chk("R9 forced again", int'(pend_cnt), 3);

    for (int n = 0; n < 4000; n++) begin
      logic [N_SRC-1:0] up = '0, dn = '0;
      for (int i = 0; i < N_GEN; i++) if ($urandom_range(7) == 0) lv[i] = ~lv[i];
      for (int i = 0; i < N_SRC; i++) begin
        if ($urandom_range(5) == 0) up[i] = 1'b1;
        if ($urandom_range(5) == 0) dn[i] = 1'b1;
      end
      step(lv, up, dn, ($urandom_range(5) == 0), 4'($urandom_range(15)),
           1'($urandom_range(1)),
           ($urandom_range(3) == 0) ? 4'hF : 4'($urandom_range(14)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule